// File: doc/BRIEF.md
# Drive Bay Presence Classifier

This block sits between a hot-plug drive bay and the PCIe downstream port that serves it. The bay accepts either a SAS or an NVMe drive. Two active-low presence contacts come from the connector. The interface-detect contact is longer, so it closes first when a drive goes in. The second presence contact closes some time later, and the data lanes close after both. The block cannot observe the moment the drive is fully seated. It therefore starts a fixed settle wait when interface-detect first reads low. When that wait ends, it reads the second contact once and classifies the drive.

Only an NVMe drive pulls the active-low presence line of the downstream port low. A SAS drive leaves that line released. A two-bit status output reports the current phase. Time is counted in pulses of a one-cycle clock enable that arrives once per millisecond. The wait length is a parameter, so a system can hide a new drive for longer, for example one second.

Both contacts pass through two-flop synchronizers before they are used. The asynchronous reset is released synchronously to the clock. A removal clears the classification at any time, and so does a bounce on interface-detect during the wait.

Top module: `bay_presence_classifier`

## Requirements
- R1: While reset is asserted, and after it is released with the bay empty, the status reads 00 (empty) and `dsp_prsnt_no` is high.
- R2: Interface-detect low for three clock edges (two synchronizer flops plus the state register) moves the status from 00 to 01 (settling). Only one input value, interface-detect low, triggers this.
- R3: While settling, the status stays 01 until exactly SETTLE_MS enable pulses have been counted. The change happens on the clock edge that carries the SETTLE_MS-th pulse.
- R4: If the synchronized second contact is high at expiry, the status becomes 10 (NVMe) and `dsp_prsnt_no` goes low.
- R5: If the synchronized second contact is low at expiry, the status becomes 11 (SAS) and `dsp_prsnt_no` stays high.
- R6: Interface-detect high, in any state, returns the status to 00 and releases `dsp_prsnt_no` high. This happens three clock edges after the pin changes.
- R7: If interface-detect bounces high during settling, the count is discarded. A later low level starts a full new wait of SETTLE_MS pulses.
- R8: Once the drive is classified, changes on the second contact do not alter the status or `dsp_prsnt_no` while interface-detect stays low.
- R9: The second contact is read only at expiry. Its level earlier in the wait has no effect on the result.
- R10: Clock cycles without an enable pulse do not advance the wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_ms_i | input | 1 | One-cycle enable, once per millisecond |
| ifdet_ni | input | 1 | Interface-detect contact, active low, mates first |
| prsnt_ni | input | 1 | Second presence contact, active low |
| dsp_prsnt_no | output | 1 | Active-low presence to the downstream port, low only for NVMe |
| bay_state_o | output | 2 | 00 empty, 01 settling, 10 NVMe, 11 SAS |

## Verification
The bench builds the block with SETTLE_MS set to 8 rather than 500. With that value, the exact edge at which settling ends can be checked pulse by pulse, at the seventh pulse and at the eighth. Several full waits, restarts after a bounce and re-insertions also fit in a short run. The timer width is derived from the parameter, so the same comparison logic is exercised as with the default value, only with a narrower counter.

// File: rtl/bay_presence_pkg.sv
package bay_presence_pkg;
  // Status encoding is visible on bay_state_o.
  typedef enum logic [1:0] {
    BAY_EMPTY    = 2'b00,
    BAY_SETTLING = 2'b01,
    BAY_NVME     = 2'b10,
    BAY_SAS      = 2'b11
  } bay_state_e;
endpackage

// File: rtl/bay_sync.sv
// Two-flop synchronizer, one chain per bit, with a per-bit reset value.
module bay_sync #(
  parameter int          WIDTH   = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic meta_q, sync_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= RST_VAL[b];
        sync_q <= RST_VAL[b];
      end else begin
        meta_q <= d_i[b];
        sync_q <= meta_q;
      end
    end
    assign q_o[b] = sync_q;
  end
endmodule

// File: rtl/bay_settle_timer.sv
// Counts enable pulses while run_i is high; done_o flags the final pulse.
module bay_settle_timer #(
  parameter int SETTLE_MS = 500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic tick_i,
  output logic done_o
);
  localparam int CW = (SETTLE_MS > 1) ? $clog2(SETTLE_MS) : 1;
  localparam logic [CW-1:0] LAST = CW'(SETTLE_MS - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i) begin
      cnt_d = '0;
    end else if (tick_i) begin
      cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign done_o = run_i && tick_i && (cnt_q == LAST);
endmodule

// File: rtl/bay_classify_fsm.sv
// Presence state machine: empty, settling, then a held decision.
module bay_classify_fsm
  import bay_presence_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ifdet_n_i,
  input  logic       prsnt_n_i,
  input  logic       expire_i,
  output logic       settling_o,
  output bay_state_e state_o
);
  bay_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (ifdet_n_i) begin
      state_d = BAY_EMPTY;
    end else begin
      unique case (state_q)
        BAY_EMPTY:    state_d = BAY_SETTLING;
        BAY_SETTLING: if (expire_i) state_d = prsnt_n_i ? BAY_NVME : BAY_SAS;
        BAY_NVME:     state_d = BAY_NVME;
        BAY_SAS:      state_d = BAY_SAS;
        default:      state_d = BAY_EMPTY;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= BAY_EMPTY;
    else         state_q <= state_d;
  end

  assign settling_o = (state_q == BAY_SETTLING);
  assign state_o    = state_q;
endmodule

// File: rtl/bay_presence_classifier.sv
// Top: reset release, pin synchronizers, settle timer, classifier.
module bay_presence_classifier
  import bay_presence_pkg::*;
#(
  parameter int SETTLE_MS = 500
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_ms_i,
  input  logic       ifdet_ni,
  input  logic       prsnt_ni,
  output logic       dsp_prsnt_no,
  output logic [1:0] bay_state_o
);
  logic       rst_meta_q, rst_sync_n;
  logic [1:0] pins_sync;
  logic       ifdet_sync, prsnt_sync;
  logic       settling, expire;
  bay_state_e state;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  bay_sync #(.WIDTH(2), .RST_VAL(2'b11)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .d_i    ({prsnt_ni, ifdet_ni}),
    .q_o    (pins_sync)
  );
  assign ifdet_sync = pins_sync[0];
  assign prsnt_sync = pins_sync[1];

  bay_settle_timer #(.SETTLE_MS(SETTLE_MS)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .run_i  (settling),
    .tick_i (tick_ms_i),
    .done_o (expire)
  );

  bay_classify_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .ifdet_n_i  (ifdet_sync),
    .prsnt_n_i  (prsnt_sync),
    .expire_i   (expire),
    .settling_o (settling),
    .state_o    (state)
  );

  assign bay_state_o  = state;
  assign dsp_prsnt_no = (state != BAY_NVME);
endmodule

// File: rtl/bay_presence_checker.sv
module bay_presence_checker #(
  parameter int SETTLE_MS = 500
) (
  input logic       clk_i,
  input logic       rst_n,
  input logic       tick,
  input logic       ifdet_s,
  input logic       prsnt_s,
  input logic       dsp_n,
  input logic [1:0] st
);
  localparam int CW = (SETTLE_MS > 1) ? $clog2(SETTLE_MS) : 1;
  localparam logic [CW-1:0] LAST = CW'(SETTLE_MS - 1);
  logic [CW-1:0] seen_q;
  logic          last_tick;

  // Independent count of pulses observed in settling.
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)              seen_q <= '0;
    else if (st != 2'b01)    seen_q <= '0;
    else if (tick)           seen_q <= seen_q + 1'b1;
  end
  assign last_tick = tick && (seen_q == LAST);

  AST_REMOVE_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_n)
    ifdet_s |=> (st == 2'b00 && dsp_n)); // R6
  AST_FIRST_MATE: assert property (@(posedge clk_i) disable iff (!rst_n)
    (st == 2'b00 && !ifdet_s) |=> st == 2'b01); // R2
  AST_NO_EARLY_DECISION: assert property (@(posedge clk_i) disable iff (!rst_n)
    (st == 2'b01 && !ifdet_s && !last_tick) |=> st == 2'b01); // R3
  AST_DECIDE_TYPE: assert property (@(posedge clk_i) disable iff (!rst_n)
    (st == 2'b01 && !ifdet_s && last_tick) |=> st == ($past(prsnt_s) ? 2'b10 : 2'b11)); // R4
  AST_HOLD_NVME: assert property (@(posedge clk_i) disable iff (!rst_n)
    (st == 2'b10 && !ifdet_s) |=> (st == 2'b10 && !dsp_n)); // R8
  AST_HOLD_SAS: assert property (@(posedge clk_i) disable iff (!rst_n)
    (st == 2'b11 && !ifdet_s) |=> (st == 2'b11 && dsp_n)); // R5
endmodule

bind bay_presence_classifier bay_presence_checker #(.SETTLE_MS(SETTLE_MS)) u_chk (
  .clk_i   (clk_i),
  .rst_n   (rst_sync_n),
  .tick    (tick_ms_i),
  .ifdet_s (ifdet_sync),
  .prsnt_s (prsnt_sync),
  .dsp_n   (dsp_prsnt_no),
  .st      (bay_state_o)
);

// File: tb/test_bay_presence_classifier.sv
`timescale 1ns/1ps
module test_bay_presence_classifier;
  localparam int SMS = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick, ifdet_n, prsnt_n;
  logic       dsp_n;
  logic [1:0] st;
  int         errors = 0;
  int         checks = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  bay_presence_classifier #(.SETTLE_MS(SMS)) i_bay_presence_classifier (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .tick_ms_i    (tick),
    .ifdet_ni     (ifdet_n),
    .prsnt_ni     (prsnt_n),
    .dsp_prsnt_no (dsp_n),
    .bay_state_o  (st)
  );

  task automatic expect_state(string req, logic [1:0] exp_st, logic exp_dsp);
    checks++;
    if (st !== exp_st || dsp_n !== exp_dsp) begin
      errors++;
      $display("FAIL %s: state=%b dsp_n=%b expected state=%b dsp_n=%b",
               req, st, dsp_n, exp_st, exp_dsp);
    end
  endtask

  task automatic steps(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulses(int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; @(negedge clk);
      tick = 1'b0; @(negedge clk);
    end
  endtask

  task automatic remove_drive();
    ifdet_n = 1'b1; prsnt_n = 1'b1; steps(3);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; tick = 1'b0; ifdet_n = 1'b1; prsnt_n = 1'b1;
    steps(3);
    expect_state("R1 in reset", 2'b00, 1'b1);
    rst_n = 1'b1; steps(5);
    expect_state("R1 after release", 2'b00, 1'b1);
  endtask

  task automatic t_nvme();
    ifdet_n = 1'b0; steps(2);
    expect_state("R2 two edges not yet", 2'b00, 1'b1);
    steps(1);
    expect_state("R2 settling", 2'b01, 1'b1);
    steps(40);
    expect_state("R10 no pulses", 2'b01, 1'b1);
    pulses(SMS - 1);
    expect_state("R3 one pulse short", 2'b01, 1'b1);
    pulses(1);
    expect_state("R4 nvme", 2'b10, 1'b0);
    prsnt_n = 1'b0; steps(6);
    expect_state("R8 nvme held", 2'b10, 1'b0);
    ifdet_n = 1'b1; steps(2);
    expect_state("R6 not before three edges", 2'b10, 1'b0);
    steps(1);
    expect_state("R6 removal from nvme", 2'b00, 1'b1);
    prsnt_n = 1'b1; steps(3);
  endtask

  task automatic t_sas();
    ifdet_n = 1'b0; steps(3);
    pulses(2);
    prsnt_n = 1'b0; steps(3);
    pulses(SMS - 2);
    expect_state("R5 sas", 2'b11, 1'b1);
    prsnt_n = 1'b1; steps(6);
    expect_state("R8 sas held", 2'b11, 1'b1);
    remove_drive();
    expect_state("R6 removal from sas", 2'b00, 1'b1);
  endtask

  task automatic t_bounce();
    ifdet_n = 1'b0; steps(3);
    pulses(SMS - 2);
    ifdet_n = 1'b1; steps(3);
    expect_state("R7 bounce to empty", 2'b00, 1'b1);
    ifdet_n = 1'b0; steps(3);
    pulses(SMS - 1);
    expect_state("R7 full wait restarted", 2'b01, 1'b1);
    pulses(1);
    expect_state("R7 classified after full wait", 2'b10, 1'b0);
    remove_drive();
  endtask

  task automatic t_late_pin();
    ifdet_n = 1'b0; prsnt_n = 1'b0; steps(3);
    pulses(SMS - 3);
    prsnt_n = 1'b1; steps(3);
    pulses(3);
    expect_state("R9 only expiry level counts", 2'b10, 1'b0);
    remove_drive();
    expect_state("R6 empty for reinsertion", 2'b00, 1'b1);
  endtask

  initial begin
    t_reset();
    t_nvme();
    t_sas();
    t_bounce();
    t_late_pin();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule